// File: doc/BRIEF.md
# Clocked-Slave Serial Word Receiver

This block receives serial words from an external master that drives both a clock line and a data line. The serial clock and the data line each pass through a synchronizer chain. Every rising edge of the serial clock shifts one data bit into a shift register, least significant bit first. When the programmed number of bits has arrived, the word moves into a two-entry holding queue. The host reads the queue one word at a time.

The host sets a few static controls: port enable, synchronous-mode select, clock-source select, continuous-receive enable, a single-receive enable that slave mode ignores, 9-bit mode and the receive interrupt enable. The block reports the oldest unread word, its ninth bit, a receive-complete flag, an interrupt request and an overrun flag.

Reception needs no action from the host while it runs. Words keep arriving and queueing while the host is idle. An enabled pending word raises the interrupt request, which the host can use as a wake request.

Top module: `sync_slave_rx`

## Requirements
- R1: Reception takes place only while `port_en_i`=1, `sync_mode_i`=1, `clk_master_i`=0 and `cont_rx_en_i`=1. With any of these conditions not met, serial clock edges queue no word.
- R2: `single_rx_en_i` has no effect. With `cont_rx_en_i`=0 and `single_rx_en_i`=1, no word is received.
- R3: Bits are sampled on rising edges of `sclk_i`, least significant bit first. In 8-bit mode (`nine_bit_i`=0), after 8 rising edges the byte appears on `rx_data_o` and `rx_bit9_o`=0.
- R4: In 9-bit mode (`nine_bit_i`=1), a word takes 9 rising edges. The first 8 bits form `rx_data_o` and the ninth (last) bit is reported on `rx_bit9_o`.
- R5: `rx_done_o` is 1 while the holding queue holds at least one unread word. A one-cycle `rd_i` pulse removes the oldest word, and the queue returns words in arrival order with a depth of 2.
- R6: `irq_o` is 1 exactly when `rx_done_o`=1 and `rx_int_en_i`=1.
- R7: If a word completes while both queue entries are full, the word is discarded and `overrun_o` becomes 1. Shifting then stops, so later words are not received.
- R8: Setting `cont_rx_en_i` to 0 clears `overrun_o` and drops any partly received word. Words already queued stay readable.
- R9: Setting `port_en_i` to 0 empties the queue and clears `rx_done_o`, `irq_o` and `overrun_o`.
- R10: An `rd_i` pulse while the queue is empty has no effect, and the next received word is returned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Serial port enable |
| sync_mode_i | input | 1 | Synchronous mode select |
| clk_master_i | input | 1 | Clock source select, 0 = external clock (slave) |
| cont_rx_en_i | input | 1 | Continuous-receive enable |
| single_rx_en_i | input | 1 | Single-receive enable, ignored in slave mode |
| nine_bit_i | input | 1 | 9-bit word select |
| rx_int_en_i | input | 1 | Receive interrupt enable |
| sclk_i | input | 1 | Serial clock from external master |
| sdata_i | input | 1 | Serial data line |
| rd_i | input | 1 | Pop strobe for the holding queue |
| rx_data_o | output | 8 | Oldest unread data byte, 0 when the queue is empty |
| rx_bit9_o | output | 1 | Ninth bit of the oldest unread word |
| rx_done_o | output | 1 | Receive-complete flag |
| irq_o | output | 1 | Receive interrupt request |
| overrun_o | output | 1 | Overrun error flag |

## Verification
The hardest state to reach is the overrun. It needs two unread words in the queue followed by a third complete word, and only then can the bench show that shifting has frozen. The stimulus stops reading and sends three words back to back, then sends a fourth that must leave no trace. It then drains the queue and checks that exactly the first two words come back. A second hard case is a word cut short by clearing the continuous-receive enable; the bench checks that the next full word lines up from bit zero.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int unsigned SSRX_DATA_W = 8;

  typedef struct packed {
    logic                   b9;
    logic [SSRX_DATA_W-1:0] data;
  } ssrx_word_t;
endpackage

// File: rtl/ssrx_edge_sync.sv
module ssrx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic data_o
);
  logic [STAGES-1:0] clk_sync_q;
  logic [STAGES-1:0] dat_sync_q;
  logic              clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync_q <= '0;
      dat_sync_q <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_sync_q <= {clk_sync_q[STAGES-2:0], sclk_i};
      dat_sync_q <= {dat_sync_q[STAGES-2:0], sdata_i};
      clk_prev_q <= clk_sync_q[STAGES-1];
    end
  end

  assign rise_o = clk_sync_q[STAGES-1] & ~clk_prev_q;
  assign data_o = dat_sync_q[STAGES-1];
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter
  import ssrx_pkg::*;
#(
  parameter int unsigned W = SSRX_DATA_W + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       rise_i,
  input  logic       bit_i,
  input  logic       nine_i,
  output logic       done_o,
  output ssrx_word_t word_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(W - 2);

  logic [W-1:0]     sr_q, sr_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign sr_nxt = {bit_i, sr_q[W-1:1]};
  assign last   = nine_i ? LAST9 : LAST8;
  assign done_o = en_i & rise_i & (cnt_q == last);

  always_comb begin
    if (nine_i) begin
      word_o.b9   = sr_nxt[W-1];
      word_o.data = sr_nxt[W-2:0];
    end else begin
      word_o.b9   = 1'b0;
      word_o.data = sr_nxt[W-1:1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i || !en_i) begin
      cnt_q <= '0;
      if (clr_i) sr_q <= '0;
    end else if (rise_i) begin
      sr_q  <= sr_nxt;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssrx_hold_fifo.sv
module ssrx_hold_fifo
  import ssrx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       push_i,
  input  ssrx_word_t wdata_i,
  input  logic       pop_i,
  output ssrx_word_t rdata_o,
  output logic       empty_o,
  output logic       full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  ssrx_word_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_ptr_q] <= wdata_i;
        wr_ptr_q <= (wr_ptr_q == PTR_MAX) ? '0 : wr_ptr_q + 1'b1;
      end
      if (do_pop) rd_ptr_q <= (rd_ptr_q == PTR_MAX) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import ssrx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_DEPTH  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   port_en_i,
  input  logic                   sync_mode_i,
  input  logic                   clk_master_i,
  input  logic                   cont_rx_en_i,
  input  logic                   single_rx_en_i,
  input  logic                   nine_bit_i,
  input  logic                   rx_int_en_i,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   rd_i,
  output logic [SSRX_DATA_W-1:0] rx_data_o,
  output logic                   rx_bit9_o,
  output logic                   rx_done_o,
  output logic                   irq_o,
  output logic                   overrun_o
);
  localparam int unsigned WORD_W = SSRX_DATA_W + 1;

  logic       slave_active, rx_run, clr_all;
  logic       s_rise, s_data;
  logic       word_done, q_empty, q_full;
  logic       ovr_q;
  ssrx_word_t word_in, word_out;
  logic       unused_single_rx;

  // slave mode ignores the single-receive request
  assign unused_single_rx = single_rx_en_i;

  assign slave_active = port_en_i & sync_mode_i & ~clk_master_i;
  assign rx_run       = slave_active & cont_rx_en_i & ~ovr_q;
  assign clr_all      = ~port_en_i;

  ssrx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .rise_o  (s_rise),
    .data_o  (s_data)
  );

  ssrx_shifter #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_all),
    .en_i   (rx_run),
    .rise_i (s_rise),
    .bit_i  (s_data),
    .nine_i (nine_bit_i),
    .done_o (word_done),
    .word_o (word_in)
  );

  ssrx_hold_fifo #(.DEPTH(HOLD_DEPTH)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_all),
    .push_i  (word_done),
    .wdata_i (word_in),
    .pop_i   (rd_i),
    .rdata_o (word_out),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  // overrun: sticky until continuous-receive enable drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ovr_q <= 1'b0;
    else if (clr_all || !cont_rx_en_i)  ovr_q <= 1'b0;
    else if (word_done && q_full)       ovr_q <= 1'b1;
  end

  assign rx_data_o = word_out.data;
  assign rx_bit9_o = word_out.b9;
  assign rx_done_o = ~q_empty;
  assign irq_o     = ~q_empty & rx_int_en_i;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic port_en_i,
  input logic sync_mode_i,
  input logic clk_master_i,
  input logic cont_rx_en_i,
  input logic rx_int_en_i,
  input logic rx_done_o,
  input logic irq_o,
  input logic overrun_o
);
  a_r1_no_rx_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_en_i && sync_mode_i && !clk_master_i && cont_rx_en_i) |=> !$rose(rx_done_o));

  a_r6_irq_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_done_o);

  a_r6_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_int_en_i);

  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && port_en_i && cont_rx_en_i) |=> overrun_o);

  a_r7_overrun_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> rx_done_o);

  a_r8_clear_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_rx_en_i |=> !overrun_o);

  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (!rx_done_o && !irq_o && !overrun_o));
endmodule

bind sync_slave_rx ssrx_checker u_ssrx_chk (.*);

// File: tb/tb_sync_slave_rx.sv
`timescale 1ns/1ps
module tb_sync_slave_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic port_en = 0, sync_mode = 0, clk_master = 0, cont_en = 0, single_en = 0;
  logic nine = 0, int_en = 0, sclk = 0, sdata = 0, rd = 0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_done, irq, ovr;

  int checks = 0;
  int failures = 0;
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;

  sync_slave_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .port_en_i(port_en), .sync_mode_i(sync_mode),
    .clk_master_i(clk_master), .cont_rx_en_i(cont_en), .single_rx_en_i(single_en),
    .nine_bit_i(nine), .rx_int_en_i(int_en), .sclk_i(sclk), .sdata_i(sdata),
    .rd_i(rd), .rx_data_o(rx_data), .rx_bit9_o(rx_bit9), .rx_done_o(rx_done),
    .irq_o(irq), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each popped word with the scoreboard
  always @(posedge clk) begin
    if (rst_ni && rd && rx_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected word", {23'd0, rx_bit9, rx_data}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({rx_bit9, rx_data} == e, "R3/R4/R5 word", {23'd0, rx_bit9, rx_data}, {23'd0, e});
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_word(input logic [8:0] w, input int nbits, input bit keep);
    for (int i = 0; i < nbits; i++) send_bit(w[i]);
    if (keep) exp_q.push_back((nbits == 9) ? w : {1'b0, w[7:0]});
    repeat (4) @(negedge clk);
  endtask

  task automatic read_word();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!rx_done, "R5 reset done", rx_done, 0);
    chk(!irq, "R6 reset irq", irq, 0);
    chk(!ovr, "R7 reset overrun", ovr, 0);

    port_en = 1; sync_mode = 1; clk_master = 0; cont_en = 1;
    @(negedge clk);

    // R3: 8-bit LSB first
    send_word(9'h0A5, 8, 1);
    chk(rx_done, "R5 done after word", rx_done, 1);
    chk(!irq, "R6 irq masked", irq, 0);
    chk(rx_bit9 == 1'b0, "R3 ninth bit zero", rx_bit9, 0);
    read_word();
    chk(!rx_done, "R5 done cleared after read", rx_done, 0);

    // R6
    int_en = 1;
    send_word(9'h03C, 8, 1);
    chk(irq, "R6 irq raised", irq, 1);
    read_word();
    chk(!irq, "R6 irq cleared", irq, 0);

    // R4: 9-bit words, two queued, read in order (R5)
    nine = 1;
    send_word(9'h15A, 9, 1);
    send_word(9'h0C3, 9, 1);
    chk(rx_bit9 == 1'b1, "R4 ninth bit", rx_bit9, 1);
    read_word();
    read_word();
    chk(!rx_done, "R5 drained", rx_done, 0);
    nine = 0;

    // R2: single-receive enable alone
    cont_en = 0; single_en = 1;
    send_word(9'h0FF, 8, 0);
    chk(!rx_done, "R2 single enable ignored", rx_done, 0);
    single_en = 0; cont_en = 1;

    // R1: master clock source, then async mode
    clk_master = 1;
    send_word(9'h011, 8, 0);
    chk(!rx_done, "R1 master clock select", rx_done, 0);
    clk_master = 0; sync_mode = 0;
    send_word(9'h022, 8, 0);
    chk(!rx_done, "R1 async mode", rx_done, 0);
    sync_mode = 1;

    // R7: overrun
    send_word(9'h001, 8, 1);
    send_word(9'h002, 8, 1);
    chk(!ovr, "R7 no overrun at two", ovr, 0);
    send_word(9'h003, 8, 0);
    chk(ovr, "R7 overrun set", ovr, 1);
    send_word(9'h004, 8, 0);
    chk(ovr, "R7 overrun held", ovr, 1);
    read_word();
    read_word();
    chk(!rx_done, "R7 extra words discarded", rx_done, 0);

    // R8: clear by toggling continuous enable, partial word dropped
    @(negedge clk); cont_en = 0;
    @(negedge clk);
    chk(!ovr, "R8 overrun cleared", ovr, 0);
    cont_en = 1;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    @(negedge clk); cont_en = 0;
    repeat (2) @(negedge clk); cont_en = 1;
    send_word(9'h081, 8, 1);
    chk(rx_done, "R8 word after partial", rx_done, 1);
    read_word();

    // R9: port disable flushes
    send_word(9'h055, 8, 0);
    chk(irq, "R9 pending before disable", irq, 1);
    @(negedge clk); port_en = 0;
    @(negedge clk);
    chk(!rx_done && !irq, "R9 flushed", {rx_done, irq}, 0);
    port_en = 1;
    @(negedge clk);
    chk(!rx_done, "R9 stays empty", rx_done, 0);

    // R10: read while empty
    read_word();
    chk(!rx_done, "R10 empty read no effect", rx_done, 0);
    send_word(9'h0E7, 8, 1);
    read_word();
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule